// File: doc/BRIEF.md
# Switch Reset and Address-Table Flush Sequencer

This block is a control state machine that brings a managed Ethernet switch out of a soft reset into plain (unmanaged) forwarding and then clears its address table. It does not touch the switch registers itself. Instead it issues byte-wide read and write requests, one at a time, to a separate register-access engine and waits for each acknowledge. Every request targets one fixed register page, set by a parameter.

A single start pulse launches a fixed order of steps. First a soft reset, done as a read-modify-write with a bounded poll until the reset flag self-clears. Next a check of the forwarding-enable bit, with a write and a read-back only when the bit is clear. Then the CPU port is enabled for dumb forwarding. Last comes a fast-age flush, which is polled to completion and then returned to the default dynamic-only aging mode. The sequence ends with a one-cycle done pulse and a status code, which stays valid until the next start.

Top module: `swf_seq_top`

## Requirements
- R1: After reset, busy, done and acc_req are low. A start pulse while busy is high is ignored and does not begin a second sequence.
- R2: The sequence first reads register 0x79 and writes back the value read with bits 7, 6 and 4 set.
- R3: Register 0x79 is then polled until bit 7 reads 0. There are at most RST_POLLS reads, with at least WAIT_CYC idle cycles between consecutive reads. If bit 7 is still 1 on the last read, the run ends with status 1.
- R4: Register 0x0B is read next. If bit 1 is 1, no write goes to 0x0B. Otherwise the value read is written back with bit 0 cleared and bit 1 set, and 0x0B is read again.
- R5: If bit 1 of that read-back is 0, the run ends with status 2 and no further requests are issued.
- R6: Register 0x22 is read and written back with bit 6 set.
- R7: The flush writes 0x83 to register 0x88 and polls 0x88 until bit 7 reads 0. There are at most FLUSH_POLLS reads, spaced as in R3. If bit 7 is still 1 on the last read, the run ends with status 3.
- R8: After a completed flush, 0x02 is written to register 0x88 and the run ends with status 0.
- R9: An acknowledge with acc_err high ends the run with status 4 in the next cycle. No further request is issued.
- R10: done is a one-cycle pulse. status holds its value until the next accepted start. While acc_req is high and unacknowledged, acc_we, acc_addr and acc_wdata stay stable.

Status codes are 0 ok, 1 reset timeout, 2 enable failure, 3 flush timeout and 4 access error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that begins the sequence when idle |
| busy | output | 1 | High from an accepted start until the done cycle, inclusive |
| done | output | 1 | One-cycle end-of-sequence pulse |
| status | output | 3 | Result code; see the end of Requirements |
| acc_req | output | 1 | Access request, held until acknowledged |
| acc_we | output | 1 | 1 = write, 0 = read |
| acc_page | output | 8 | Register page (parameter PAGE) |
| acc_addr | output | 8 | Register offset within the page |
| acc_wdata | output | 8 | Write data |
| acc_ack | input | 1 | One-cycle acknowledge of the current request |
| acc_rdata | input | 8 | Read data, valid with acc_ack |
| acc_err | input | 1 | Access failed, valid with acc_ack |

## Verification
The bench targets both poll limits exactly at the boundary: a flag that clears on the last permitted read, and a flag that stays set through it. An off-by-one counter would either report a false timeout or poll one time too many. It sets up a forwarding register that is already enabled, where a wrong design would still write to it, and a register whose enable bit cannot be set, where a wrong design would carry on to the flush instead of failing. It injects access errors early in the sequence, where a design that ignored the error flag would keep issuing requests or report success. It also pulses start again mid-run, where a design that did not ignore it would restart the reset step.

// File: rtl/swf_pkg.sv
package swf_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_RD, S_RST_WR, S_RST_POLL, S_RST_WAIT,
    S_MODE_RD, S_MODE_WR, S_MODE_CHK, S_DUMB_RD, S_DUMB_WR,
    S_AGE_WR, S_AGE_POLL, S_AGE_WAIT, S_AGE_REST, S_END
  } seq_state_t;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_RST_TMO = 3'd1,
    ST_EN_FAIL = 3'd2,
    ST_AGE_TMO = 3'd3,
    ST_ACC_ERR = 3'd4
  } seq_status_t;

  localparam logic [7:0] REG_SOFTRST = 8'h79;
  localparam logic [7:0] REG_MODE    = 8'h0B;
  localparam logic [7:0] REG_SWCTL   = 8'h22;
  localparam logic [7:0] REG_AGE     = 8'h88;

  localparam logic [7:0] SOFTRST_SET = 8'hD0;
  localparam int         BUSY_BIT    = 7;
  localparam int         FWD_EN_BIT  = 1;
  localparam logic [7:0] MODE_MGD    = 8'h01;
  localparam logic [7:0] MODE_FWD    = 8'h02;
  localparam logic [7:0] DUMB_FWD    = 8'h40;
  localparam logic [7:0] AGE_START   = 8'h83;
  localparam logic [7:0] AGE_DEFAULT = 8'h02;

endpackage

// File: rtl/swf_rst_sync.sv
module swf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/swf_poll_cnt.sv
module swf_poll_cnt #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] lim,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == lim - 1'b1);
endmodule

// File: rtl/swf_wait_tmr.sv
module swf_wait_tmr #(
  parameter int WAIT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic zero
);
  localparam int TW = $clog2(WAIT_CYC + 1);
  localparam logic [TW-1:0] LOADV = TW'(WAIT_CYC - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= LOADV;
    else if (run && !zero)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/swf_seq_top.sv
module swf_seq_top #(
  parameter logic [7:0] PAGE        = 8'h00,
  parameter int         RST_POLLS   = 1000,
  parameter int         FLUSH_POLLS = 10,
  parameter int         WAIT_CYC    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output logic [2:0] status,
  output logic       acc_req,
  output logic       acc_we,
  output logic [7:0] acc_page,
  output logic [7:0] acc_addr,
  output logic [7:0] acc_wdata,
  input  logic       acc_ack,
  input  logic [7:0] acc_rdata,
  input  logic       acc_err
);
  import swf_pkg::*;

  localparam int MAXP = (RST_POLLS > FLUSH_POLLS) ? RST_POLLS : FLUSH_POLLS;
  localparam int CW   = $clog2(MAXP + 1);

  logic        srst_n;
  seq_state_t  state_q, state_d;
  seq_status_t status_q, status_d;
  logic [7:0]  data_q;
  logic        cap_en, st_en;
  logic        poll_clr, poll_inc, poll_last;
  logic        tmr_load, tmr_run, tmr_zero;
  logic        age_phase;
  logic [CW-1:0] lim;
  logic        ok_ack;

  swf_rst_sync u_rsync (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  assign age_phase = (state_q == S_AGE_WR) || (state_q == S_AGE_POLL) ||
                     (state_q == S_AGE_WAIT);
  assign lim = age_phase ? CW'(FLUSH_POLLS) : CW'(RST_POLLS);

  swf_poll_cnt #(.CW(CW)) u_poll (
    .clk(clk), .rst_n(srst_n), .clr(poll_clr), .inc(poll_inc),
    .lim(lim), .last(poll_last)
  );

  swf_wait_tmr #(.WAIT_CYC(WAIT_CYC)) u_tmr (
    .clk(clk), .rst_n(srst_n), .load(tmr_load), .run(tmr_run), .zero(tmr_zero)
  );

  // Request decode (Moore, from state and captured data)
  always_comb begin
    acc_req   = 1'b1;
    acc_we    = 1'b0;
    acc_addr  = 8'h00;
    acc_wdata = 8'h00;
    unique case (state_q)
      S_RST_RD, S_RST_POLL: acc_addr = REG_SOFTRST;
      S_RST_WR:   begin acc_we = 1'b1; acc_addr = REG_SOFTRST; acc_wdata = data_q | SOFTRST_SET; end
      S_MODE_RD, S_MODE_CHK: acc_addr = REG_MODE;
      S_MODE_WR:  begin acc_we = 1'b1; acc_addr = REG_MODE; acc_wdata = (data_q & ~MODE_MGD) | MODE_FWD; end
      S_DUMB_RD:  acc_addr = REG_SWCTL;
      S_DUMB_WR:  begin acc_we = 1'b1; acc_addr = REG_SWCTL; acc_wdata = data_q | DUMB_FWD; end
      S_AGE_WR:   begin acc_we = 1'b1; acc_addr = REG_AGE; acc_wdata = AGE_START; end
      S_AGE_POLL: acc_addr = REG_AGE;
      S_AGE_REST: begin acc_we = 1'b1; acc_addr = REG_AGE; acc_wdata = AGE_DEFAULT; end
      default:    acc_req = 1'b0;
    endcase
  end

  assign ok_ack = acc_ack && !acc_err;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    st_en    = 1'b0;
    cap_en   = 1'b0;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    tmr_load = 1'b0;
    tmr_run  = 1'b0;
    if (acc_req && acc_ack && acc_err) begin
      state_d = S_END; status_d = ST_ACC_ERR; st_en = 1'b1;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          state_d = S_RST_RD; status_d = ST_OK; st_en = 1'b1;
        end
        S_RST_RD: if (ok_ack) begin cap_en = 1'b1; state_d = S_RST_WR; end
        S_RST_WR: if (ok_ack) begin poll_clr = 1'b1; state_d = S_RST_POLL; end
        S_RST_POLL: if (ok_ack) begin
          if (!acc_rdata[BUSY_BIT]) state_d = S_MODE_RD;
          else if (poll_last) begin state_d = S_END; status_d = ST_RST_TMO; st_en = 1'b1; end
          else begin poll_inc = 1'b1; tmr_load = 1'b1; state_d = S_RST_WAIT; end
        end
        S_RST_WAIT: begin tmr_run = 1'b1; if (tmr_zero) state_d = S_RST_POLL; end
        S_MODE_RD: if (ok_ack) begin
          cap_en  = 1'b1;
          state_d = acc_rdata[FWD_EN_BIT] ? S_DUMB_RD : S_MODE_WR;
        end
        S_MODE_WR: if (ok_ack) state_d = S_MODE_CHK;
        S_MODE_CHK: if (ok_ack) begin
          if (acc_rdata[FWD_EN_BIT]) state_d = S_DUMB_RD;
          else begin state_d = S_END; status_d = ST_EN_FAIL; st_en = 1'b1; end
        end
        S_DUMB_RD: if (ok_ack) begin cap_en = 1'b1; state_d = S_DUMB_WR; end
        S_DUMB_WR: if (ok_ack) state_d = S_AGE_WR;
        S_AGE_WR:  if (ok_ack) begin poll_clr = 1'b1; state_d = S_AGE_POLL; end
        S_AGE_POLL: if (ok_ack) begin
          if (!acc_rdata[BUSY_BIT]) state_d = S_AGE_REST;
          else if (poll_last) begin state_d = S_END; status_d = ST_AGE_TMO; st_en = 1'b1; end
          else begin poll_inc = 1'b1; tmr_load = 1'b1; state_d = S_AGE_WAIT; end
        end
        S_AGE_WAIT: begin tmr_run = 1'b1; if (tmr_zero) state_d = S_AGE_POLL; end
        S_AGE_REST: if (ok_ack) begin state_d = S_END; status_d = ST_OK; st_en = 1'b1; end
        S_END:   state_d = S_IDLE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q  <= S_IDLE;
      status_q <= ST_OK;
      data_q   <= 8'h00;
    end else begin
      state_q <= state_d;
      if (st_en)  status_q <= status_d;
      if (cap_en) data_q   <= acc_rdata;
    end
  end

  assign busy     = (state_q != S_IDLE);
  assign done     = (state_q == S_END);
  assign status   = status_q;
  assign acc_page = PAGE;
endmodule

// File: rtl/swf_seq_chk.sv
module swf_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [2:0] status,
  input logic       acc_req,
  input logic       acc_we,
  input logic [7:0] acc_addr,
  input logic [7:0] acc_wdata,
  input logic       acc_ack,
  input logic       acc_err
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !acc_req);

  assert_rst_wdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_we && acc_addr == 8'h79) |-> ((acc_wdata & 8'hD0) == 8'hD0));

  assert_mode_wdata_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_we && acc_addr == 8'h0B) |-> (acc_wdata[1:0] == 2'b10));

  assert_age_wdata_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_we && acc_addr == 8'h88) |-> (acc_wdata == 8'h83 || acc_wdata == 8'h02));

  assert_err_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_ack && acc_err) |=> (done && !acc_req && status == 3'd4));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_ack) |=> (acc_req && $stable(acc_we) && $stable(acc_addr) && $stable(acc_wdata)));
endmodule

bind swf_seq_top swf_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .status(status),
  .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr),
  .acc_wdata(acc_wdata), .acc_ack(acc_ack), .acc_err(acc_err)
);

// File: tb/sim_swf_seq_top.sv
`timescale 1ns/1ps
module sim_swf_seq_top;
  localparam int RSTP = 1000, FLP = 10, WC = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, acc_req, acc_we;
  logic [2:0] status;
  logic [7:0] acc_page, acc_addr, acc_wdata, acc_rdata;
  logic acc_ack = 1'b0, acc_err = 1'b0;

  always #4 clk = ~clk;

  swf_seq_top #(.PAGE(8'h00), .RST_POLLS(RSTP), .FLUSH_POLLS(FLP), .WAIT_CYC(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .status(status), .acc_req(acc_req), .acc_we(acc_we), .acc_page(acc_page),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_ack(acc_ack),
    .acc_rdata(acc_rdata), .acc_err(acc_err)
  );

  // Register-access engine model
  logic [7:0] mem [256];
  int rst_left, age_left, rst_cfg, age_cfg, err_at, n_acc, cyc;
  int rst_reads, age_reads, mode_wr, age_wr, last_poll_ack, min_gap;
  bit stuck, pend;
  int lat;
  logic [7:0] p_addr, p_wdata;
  logic p_we;
  initial acc_rdata = 8'h00;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (acc_ack) begin
      acc_ack <= 1'b0; acc_err <= 1'b0;
    end else if (pend) begin
      if (lat == 0) begin
        pend = 1'b0;
        acc_ack <= 1'b1;
        if (n_acc == err_at) acc_err <= 1'b1;
        else if (p_we) begin
          case (p_addr)
            8'h79: begin mem[8'h79] = p_wdata & 8'h7F; if (p_wdata[7]) rst_left = rst_cfg; end
            8'h88: begin mem[8'h88] = p_wdata & 8'h7F; age_wr++; if (p_wdata[7]) age_left = age_cfg; end
            8'h0B: begin mode_wr++; mem[8'h0B] = stuck ? (p_wdata & 8'hFD) : p_wdata; end
            default: mem[p_addr] = p_wdata;
          endcase
        end else begin
          case (p_addr)
            8'h79: begin rst_reads++; acc_rdata <= mem[8'h79] | ((rst_left > 0) ? 8'h80 : 8'h00);
                         if (rst_left > 0) rst_left--; last_poll_ack = cyc; end
            8'h88: begin age_reads++; acc_rdata <= mem[8'h88] | ((age_left > 0) ? 8'h80 : 8'h00);
                         if (age_left > 0) age_left--; last_poll_ack = cyc; end
            default: acc_rdata <= mem[p_addr];
          endcase
        end
      end else lat--;
    end else if (acc_req && rst_n) begin
      pend = 1'b1; p_addr = acc_addr; p_we = acc_we; p_wdata = acc_wdata;
      lat = $urandom_range(0, 2); n_acc++;
      if (!acc_we && (acc_addr == 8'h79 || acc_addr == 8'h88) && last_poll_ack > 0
          && (cyc - last_poll_ack) < min_gap)
        min_gap = cyc - last_poll_ack;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int exp_status(input logic [7:0] m0b, input int rb, input int ab,
                                    input bit stk, input int ea);
    if (ea > 0) return 4;
    if (rb >= RSTP) return 1;
    if (!m0b[1] && stk) return 2;
    if (ab >= FLP) return 3;
    return 0;
  endfunction

  task automatic run(input logic [7:0] i79, input logic [7:0] i0b, input logic [7:0] i22,
                     input int rb, input int ab, input bit stk, input int ea, input bit restart);
    int es, w;
    logic [7:0] e0b;
    mem[8'h79] = i79; mem[8'h0B] = i0b; mem[8'h22] = i22; mem[8'h88] = 8'h02;
    rst_cfg = rb; age_cfg = ab; stuck = stk; err_at = ea;
    rst_left = 0; age_left = 0; n_acc = 0; rst_reads = 0; age_reads = 0;
    mode_wr = 0; age_wr = 0; last_poll_ack = 0; min_gap = 1 << 30;
    es = exp_status(i0b, rb, ab, stk, ea);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    w = 0;
    while (!done && w < 20000) begin
      @(negedge clk); w++;
      if (restart && w == 6) start = 1'b1; else start = 1'b0;
    end
    start = 1'b0;
    chk(w < 20000, "R10 done reached", w, 0);
    chk(status == es[2:0], "R10 status at done", status, es);
    if (ea > 0) begin
      chk(n_acc == ea, "R9 no request after error", n_acc, ea);
    end else begin
      chk(rst_reads == imin(rb + 1, RSTP) + 1, "R3 reset poll reads", rst_reads, imin(rb + 1, RSTP) + 1);
      chk(mem[8'h79] == ((i79 | 8'h50) & 8'h7F), "R2 reset rmw", mem[8'h79], (i79 | 8'h50) & 8'h7F);
      if (rst_reads > 2) chk(min_gap >= WC, "R3 poll spacing", min_gap, WC);
      if (es != 1) begin
        e0b = i0b[1] ? i0b : (stk ? (i0b & 8'hFC) : ((i0b & 8'hFE) | 8'h02));
        chk(mode_wr == (i0b[1] ? 0 : 1), "R4 mode write count", mode_wr, i0b[1] ? 0 : 1);
        chk(mem[8'h0B] == e0b, "R4 mode value", mem[8'h0B], e0b);
      end
      if (es == 2) chk(mem[8'h22] == i22 && age_wr == 0, "R5 stop after enable failure", mem[8'h22], i22);
      if (es == 0 || es == 3) begin
        chk(mem[8'h22] == (i22 | 8'h40), "R6 dumb forward set", mem[8'h22], i22 | 8'h40);
        chk(age_reads == imin(ab + 1, FLP), "R7 flush poll reads", age_reads, imin(ab + 1, FLP));
      end
      if (es == 3) chk(age_wr == 1 && mem[8'h88] == 8'h03, "R7 flush timeout no restore", age_wr, 1);
      if (es == 0) chk(age_wr == 2 && mem[8'h88] == 8'h02, "R8 default aging restored", mem[8'h88], 2);
    end
    @(negedge clk);
    chk(!done, "R10 done one cycle", done, 0);
    chk(status == es[2:0], "R10 status held", status, es);
    if (restart) begin
      repeat (5) @(negedge clk);
      chk(!busy && n_acc == (ea > 0 ? ea : n_acc), "R1 start ignored while busy", busy, 0);
    end
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    cyc = 0; pend = 1'b0; lat = 0; err_at = 0; n_acc = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !acc_req, "R1 reset state", {busy, done, acc_req}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !acc_req, "R1 idle after release", {busy, acc_req}, 0);

    run(8'h00, 8'h00, 8'h00, 2, 1, 0, 0, 0);     // plain success
    run(8'h0F, 8'h03, 8'h81, 0, 0, 0, 0, 1);     // enable already set, restart pulse
    run(8'h00, 8'h03, 8'h00, 0, 0, 1, 0, 0);     // stuck but already enabled
    run(8'h21, 8'h01, 8'h12, 1, 0, 1, 0, 0);     // R5 enable failure
    run(8'h00, 8'h00, 8'h00, RSTP - 1, 0, 0, 0, 0); // last permitted reset poll
    run(8'h00, 8'h00, 8'h00, RSTP, 0, 0, 0, 0);  // R3 reset timeout
    run(8'h00, 8'h00, 8'h00, 0, FLP - 1, 0, 0, 0); // last permitted flush poll
    run(8'h00, 8'h00, 8'h00, 0, FLP, 0, 0, 0);   // R7 flush timeout
    run(8'h00, 8'h00, 8'h00, 0, 0, 0, 1, 0);     // R9 error on first access
    run(8'h00, 8'h00, 8'h00, 3, 0, 0, 3, 1);     // R9 error during poll, restart pulse

    for (int k = 0; k < 30; k++) begin
      logic [7:0] a, b, c;
      int rb, ab, ea;
      bit stk;
      a = 8'($urandom); b = 8'($urandom); c = 8'($urandom);
      rb = $urandom_range(0, 5); ab = $urandom_range(0, FLP + 1);
      stk = ($urandom_range(0, 3) == 0);
      ea = ($urandom_range(0, 5) == 0) ? $urandom_range(1, 5) : 0;
      run(a, b, c, rb, ab, stk, ea, 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule